// File: doc/BRIEF.md
# Rewindable Word Queue with Occupancy Flags

This block is a 2048-entry, 9-bit-wide first-in first-out queue driven from one system clock. Single-cycle write and read requests move words in and out. Three active-low outputs report whether the queue is empty, completely full, or holding more than half its capacity. A synchronous active-low clear input empties the queue. An active-low rewind input moves only the read side back to the first stored location, so the words written since the last clear can be read out again.

A request that cannot be served at once is kept, not dropped. A read that arrives while the queue is empty is held and completes as soon as a word has been written. A write that arrives while the queue is full is held, with its data, and completes as soon as a read has made room. This lets a producer and a consumer run close together around the empty and full boundaries without a retry protocol. Read data comes from a register and is marked by a one-cycle valid strobe.

Top module: `retx_fifo`

## Requirements
- R1: Words are read out in the order they were written. The storage holds 2048 words of 9 bits.
- R2: In a cycle where clr_ni is low, occupancy, both addresses and any held requests are cleared, and read, write and rewind requests in that cycle are ignored. After that edge empty_no=0, full_no=1 and half_no=1.
- R3: A read is accepted only while the queue holds at least one word. The word read appears on rdata_o after the clock edge that accepts it, and rvalid_o is 1 for exactly that one cycle. rvalid_o is 0 in every other cycle.
- R4: A write is accepted only while the queue holds fewer than 2048 words. full_no is 0 exactly when 2048 words are stored.
- R5: half_no is 0 when more than 1024 words are stored and 1 when 1024 or fewer are stored.
- R6: A read and a write accepted in the same cycle leave the occupancy unchanged.
- R7: A read that arrives while the queue is empty is held. It is accepted at the first edge at which the queue is non-empty, which is the edge after the write that fills it. rvalid_o follows one cycle later. Further reads that arrive while it is held merge into it.
- R8: A write that arrives while the queue is full is held together with its data. It is accepted at the first edge after a read has made room. Further writes that arrive while it is held are ignored.
- R9: In a cycle where rewind_ni is low and clr_ni is high, the read address returns to location zero and the write address keeps its value. Read and write requests in that cycle are ignored, and held requests are discarded. The occupancy becomes the number of words written since the last clear, or 2048 if the write address has wrapped. The flags are valid in the cycle after the rewind.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_ni | input | 1 | Synchronous queue clear, active low |
| rewind_ni | input | 1 | Read-side rewind, active low |
| wr_i | input | 1 | Write request, one cycle |
| wdata_i | input | 9 | Write data |
| rd_i | input | 1 | Read request, one cycle |
| rdata_o | output | 9 | Registered read data |
| rvalid_o | output | 1 | Read data valid strobe |
| empty_no | output | 1 | Low when no word is stored |
| full_no | output | 1 | Low when 2048 words are stored |
| half_no | output | 1 | Low when more than 1024 words are stored |

## Verification
The assertions assume that clear and rewind are level inputs that are sampled synchronously. They also assume that a rewind is meaningful only while no more than one buffer's worth of words has been written since the last clear. The stimulus changes inputs only on the falling clock edge. It applies rewind only after short write runs or after exactly one complete fill, and it drives requests into clear and rewind cycles on purpose, to show that they are ignored. It also pushes the queue to both the empty and the full boundary with held requests pending.

// File: rtl/retx_fifo_pkg.sv
package retx_fifo_pkg;
  typedef struct packed {
    logic empty_n;
    logic full_n;
    logic half_n;
  } flags_t;
endpackage

// File: rtl/retx_fifo_hold.sv
module retx_fifo_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flush_i,
  input  logic req_i,
  input  logic ok_i,
  output logic go_o,
  output logic pend_o
);
  logic pend_q;
  logic want;

  assign want   = req_i | pend_q;
  assign go_o   = want & ok_i & ~flush_i;
  assign pend_o = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= want & ~ok_i & ~flush_i;
  end
endmodule

// File: rtl/retx_fifo_ptrs.sv
module retx_fifo_ptrs
  import retx_fifo_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          rewind_i,
  input  logic          rd_go_i,
  input  logic          wr_go_i,
  output logic [AW-1:0] rd_addr_o,
  output logic [AW-1:0] wr_addr_o,
  output logic          rd_ok_o,
  output logic          wr_ok_o,
  output flags_t        flags_o
);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_C = CW'(DEPTH / 2);
  localparam logic [AW-1:0] LAST_A = AW'(DEPTH - 1);

  logic [AW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;
  logic          wrap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q   <= '0;
      wr_q   <= '0;
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else if (clr_i) begin
      rd_q   <= '0;
      wr_q   <= '0;
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else if (rewind_i) begin
      rd_q  <= '0;
      cnt_q <= wrap_q ? FULL_C : {1'b0, wr_q};
    end else begin
      if (rd_go_i) rd_q <= (rd_q == LAST_A) ? '0 : rd_q + 1'b1;
      if (wr_go_i) begin
        wr_q <= (wr_q == LAST_A) ? '0 : wr_q + 1'b1;
        if (wr_q == LAST_A) wrap_q <= 1'b1;
      end
      case ({wr_go_i, rd_go_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rd_addr_o       = rd_q;
  assign wr_addr_o       = wr_q;
  assign rd_ok_o         = (cnt_q != '0);
  assign wr_ok_o         = (cnt_q != FULL_C);
  assign flags_o.empty_n = (cnt_q != '0);
  assign flags_o.full_n  = (cnt_q != FULL_C);
  assign flags_o.half_n  = (cnt_q <= HALF_C);

  // R4
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL_C);
  // R2
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0) && (rd_q == '0) && (wr_q == '0));
  // R9
  rewind_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rewind_i && !clr_i) |=> (rd_q == '0) && $stable(wr_q));
  // R3
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_go_i |-> (cnt_q != '0));
  // R4
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_go_i |-> (cnt_q != FULL_C));
  // R6
  both_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_go_i && wr_go_i && !clr_i && !rewind_i) |=> $stable(cnt_q));
endmodule

// File: rtl/retx_fifo_mem.sv
module retx_fifo_mem #(
  parameter int DEPTH = 2048,
  parameter int DW    = 9,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_valid_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rd_data_o <= mem_q[rd_addr_i];
    end
  end

  // R3
  rvalid_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o);
  // R3
  rvalid_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rd_valid_o);
  // R1
  rdata_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

// File: rtl/retx_fifo.sv
module retx_fifo
  import retx_fifo_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int DW    = 9,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_ni,
  input  logic          rewind_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o,
  output logic          empty_no,
  output logic          full_no,
  output logic          half_no
);
  logic          clr, rewind, flush;
  logic          rd_go, wr_go, rd_ok, wr_ok, rd_pend, wr_pend;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] wd_q, wr_data;
  flags_t        flags;

  assign clr    = ~clr_ni;
  assign rewind = ~rewind_ni & clr_ni;
  assign flush  = clr | rewind;

  retx_fifo_hold u_rd_hold (
    .clk_i (clk_i), .rst_ni (rst_ni), .flush_i (flush),
    .req_i (rd_i), .ok_i (rd_ok), .go_o (rd_go), .pend_o (rd_pend)
  );

  retx_fifo_hold u_wr_hold (
    .clk_i (clk_i), .rst_ni (rst_ni), .flush_i (flush),
    .req_i (wr_i), .ok_i (wr_ok), .go_o (wr_go), .pend_o (wr_pend)
  );

  // held write keeps the data of the request that first went pending
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  wd_q <= '0;
    else if (wr_i && !wr_pend && !wr_go && !flush) wd_q <= wdata_i;
  end

  assign wr_data = wr_pend ? wd_q : wdata_i;

  retx_fifo_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (clr), .rewind_i (rewind),
    .rd_go_i (rd_go), .wr_go_i (wr_go),
    .rd_addr_o (rd_addr), .wr_addr_o (wr_addr),
    .rd_ok_o (rd_ok), .wr_ok_o (wr_ok), .flags_o (flags)
  );

  retx_fifo_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .wr_en_i (wr_go), .wr_addr_i (wr_addr), .wr_data_i (wr_data),
    .rd_en_i (rd_go), .rd_addr_i (rd_addr),
    .rd_data_o (rdata_o), .rd_valid_o (rvalid_o)
  );

  assign empty_no = flags.empty_n;
  assign full_no  = flags.full_n;
  assign half_no  = flags.half_n;

  // R7
  rd_bubble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_pend && !empty_no && !flush) |=> (rd_pend || rvalid_o || $past(rd_go)) );
  // R7
  rd_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_pend && empty_no && !flush) |=> rvalid_o);
  // R8
  wr_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_pend && full_no && !flush) |=> !wr_pend);
  // R2
  clr_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> (!empty_no && full_no && half_no && !rd_pend && !wr_pend));
  // R9
  rewind_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rewind |=> (!rvalid_o && !rd_pend && !wr_pend));
endmodule

// File: tb/sim_retx_fifo.sv
`timescale 1ns/1ps
module sim_retx_fifo;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       clr_ni = 1'b1, rewind_ni = 1'b1, wr_i = 1'b0, rd_i = 1'b0;
  logic [8:0] wdata_i = '0;
  logic [8:0] rdata_o;
  logic       rvalid_o, empty_no, full_no, half_no;
  int         errors = 0;
  int         checks = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  retx_fifo u0 (
    .clk_i (clk), .rst_ni (rst_ni), .clr_ni (clr_ni), .rewind_ni (rewind_ni),
    .wr_i (wr_i), .wdata_i (wdata_i), .rd_i (rd_i),
    .rdata_o (rdata_o), .rvalid_o (rvalid_o),
    .empty_no (empty_no), .full_no (full_no), .half_no (half_no)
  );

  // {wr, rd, wdata[8:0], exp_valid, exp_data[8:0], exp_e, exp_f, exp_h}
  localparam logic [23:0] VEC [9] = '{
    {1'b1, 1'b0, 9'h011, 1'b0, 9'h000, 3'b111},
    {1'b1, 1'b0, 9'h122, 1'b0, 9'h000, 3'b111},
    {1'b1, 1'b1, 9'h033, 1'b1, 9'h011, 3'b111},
    {1'b0, 1'b1, 9'h000, 1'b1, 9'h122, 3'b111},
    {1'b0, 1'b1, 9'h000, 1'b1, 9'h033, 3'b011},
    {1'b0, 1'b1, 9'h000, 1'b0, 9'h000, 3'b011},
    {1'b1, 1'b0, 9'h1AB, 1'b0, 9'h000, 3'b111},
    {1'b0, 1'b0, 9'h000, 1'b1, 9'h1AB, 3'b011},
    {1'b0, 1'b0, 9'h000, 1'b0, 9'h000, 3'b011}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [8:0] d, input logic r,
                      input logic rw_n, input logic cl_n);
    wr_i = w; wdata_i = d; rd_i = r; rewind_ni = rw_n; clr_ni = cl_n;
    @(negedge clk);
  endtask

  task automatic flags(input logic [2:0] exp, input string tag);
    chk({empty_no, full_no, half_no} == exp, tag, {empty_no, full_no, half_no}, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int bad;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    flags(3'b011, "R2 reset flags");
    chk(rvalid_o == 1'b0, "R3 reset rvalid", rvalid_o, 0);
    @(negedge clk);

    // table walk: order (R1), strobe (R3), concurrency (R6), empty bubble (R7)
    foreach (VEC[i]) begin
      step(VEC[i][23], VEC[i][21:13], VEC[i][22], 1'b1, 1'b1);
      chk(rvalid_o == VEC[i][12], $sformatf("R3 vec%0d rvalid", i), rvalid_o, VEC[i][12]);
      if (VEC[i][12])
        chk(rdata_o == VEC[i][11:3], $sformatf("R1 R6 R7 vec%0d rdata", i), rdata_o, VEC[i][11:3]);
      flags(VEC[i][2:0], $sformatf("R7 vec%0d flags", i));
    end

    // R2: clear discards held read and ignores requests in its cycle
    step(1'b0, 9'h0, 1'b1, 1'b1, 1'b1);
    step(1'b1, 9'h0F0, 1'b1, 1'b0, 1'b0);
    flags(3'b011, "R2 clear flags");
    step(1'b1, 9'h007, 1'b0, 1'b1, 1'b1);
    step(1'b0, 9'h0, 1'b0, 1'b1, 1'b1);
    chk(rvalid_o == 1'b0, "R2 held read discarded", rvalid_o, 0);
    step(1'b0, 9'h0, 1'b1, 1'b1, 1'b1);
    chk(rvalid_o && rdata_o == 9'h007, "R2 first word after clear", rdata_o, 9'h007);
    flags(3'b011, "R2 clear-cycle write ignored");

    // R5 / R4 fill
    for (int i = 0; i < 1024; i++) step(1'b1, 9'(i), 1'b0, 1'b1, 1'b1);
    chk(half_no == 1'b1, "R5 half at 1024", half_no, 1);
    step(1'b1, 9'(1024), 1'b0, 1'b1, 1'b1);
    chk(half_no == 1'b0, "R5 half at 1025", half_no, 0);
    for (int i = 1025; i < 2047; i++) step(1'b1, 9'(i), 1'b0, 1'b1, 1'b1);
    chk(full_no == 1'b1, "R4 not full at 2047", full_no, 1);
    step(1'b1, 9'(2047), 1'b0, 1'b1, 1'b1);
    chk(full_no == 1'b0, "R4 full at 2048", full_no, 0);

    // R8: held write while full
    step(1'b1, 9'h155, 1'b0, 1'b1, 1'b1);
    chk(full_no == 1'b0, "R4 write refused when full", full_no, 0);
    step(1'b1, 9'h0AA, 1'b0, 1'b1, 1'b1);
    step(1'b0, 9'h0, 1'b1, 1'b1, 1'b1);
    chk(rvalid_o && rdata_o == 9'h000, "R1 head word", rdata_o, 0);
    chk(full_no == 1'b1, "R8 room after read", full_no, 1);
    step(1'b0, 9'h0, 1'b0, 1'b1, 1'b1);
    chk(full_no == 1'b0, "R8 held write completed", full_no, 0);

    bad = 0;
    for (int k = 0; k < 2048; k++) begin
      logic [8:0] e;
      step(1'b0, 9'h0, 1'b1, 1'b1, 1'b1);
      e = (k == 2047) ? 9'h155 : 9'(k + 1);
      if (!(rvalid_o && rdata_o == e)) begin
        bad++;
        if (bad < 4) $display("FAIL R1 drain k=%0d actual=%0h expected=%0h", k, rdata_o, e);
      end
      if (k == 1022) chk(half_no == 1'b0, "R5 half at 1025 on drain", half_no, 0);
      if (k == 1023) chk(half_no == 1'b1, "R5 half at 1024 on drain", half_no, 1);
    end
    checks++;
    if (bad != 0) errors++;
    flags(3'b011, "R8 extra held write ignored");
    step(1'b0, 9'h0, 1'b0, 1'b1, 1'b1);
    chk(rvalid_o == 1'b0, "R3 no strobe when idle", rvalid_o, 0);

    // R9: rewind after a short run
    step(1'b0, 9'h0, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 5; i++) step(1'b1, 9'h100 + 9'(i), 1'b0, 1'b1, 1'b1);
    step(1'b0, 9'h0, 1'b1, 1'b1, 1'b1);
    step(1'b0, 9'h0, 1'b1, 1'b1, 1'b1);
    chk(rvalid_o && rdata_o == 9'h101, "R1 second word", rdata_o, 9'h101);
    step(1'b1, 9'h0EE, 1'b1, 1'b0, 1'b1);
    chk(rvalid_o == 1'b0, "R9 read ignored in rewind", rvalid_o, 0);
    flags(3'b111, "R9 flags after rewind");
    for (int i = 0; i < 5; i++) begin
      step(1'b0, 9'h0, 1'b1, 1'b1, 1'b1);
      chk(rvalid_o && rdata_o == 9'h100 + 9'(i), "R9 replay data", rdata_o, 9'h100 + 9'(i));
    end
    flags(3'b011, "R9 write ignored in rewind");

    // R9: rewind after exactly one complete fill
    step(1'b0, 9'h0, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 2048; i++) step(1'b1, 9'(i ^ 9'h0C3), 1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 3; i++) step(1'b0, 9'h0, 1'b1, 1'b1, 1'b1);
    flags(3'b110, "R9 three below full");
    step(1'b0, 9'h0, 1'b0, 1'b0, 1'b1);
    flags(3'b100, "R9 wrapped rewind restores full");
    step(1'b0, 9'h0, 1'b1, 1'b1, 1'b1);
    chk(rvalid_o && rdata_o == 9'h0C3, "R9 wrapped replay head", rdata_o, 9'h0C3);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule